// File: doc/BRIEF.md
# Cold-Boot Program Loader

This block runs right after reset and before the processor runs any instruction. It reads a fixed-length program image from a read-only memory one byte at a time. It writes each byte to the same address in the instruction RAM. While it does this, it owns the instruction RAM port, holds the processor stopped and blocks every data-memory write.

When the last byte is stored, the loader gives the RAM port to the processor and raises a done flag. For one cycle it holds the processor's program counter at zero. On the next cycle it lets the processor run, so execution begins at address zero of the freshly loaded RAM. The done flag stays high until the next reset. A reset at any time starts the copy again from address zero.

The ROM is synchronous: the data for an address presented in one cycle is on `rom_rdata` in the next cycle.

Top module: `boot_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rom_addr` is 0. In that state `imem_we`, `boot_done`, `cpu_run`, `imem_sel_cpu`, `cpu_pc_zero` and `dmem_we` are all 0.
- R2: Each image word k takes two cycles. In a read cycle `rom_addr` equals k and `imem_we` is 0. In the write cycle that follows, `imem_we` is 1, `imem_addr` equals k and `imem_wdata` equals the byte the ROM returned for address k.
- R3: Words are copied in ascending order from address 0 to IMG_LEN-1. There are exactly IMG_LEN RAM writes, and `imem_we` is never high in two consecutive cycles.
- R4: `cpu_run` stays 0 for as long as the copy is in progress.
- R5: While the loader owns the port, `imem_addr` follows the loader's address and ignores `cpu_fetch_addr`.
- R6: While the loader owns the port, `dmem_we` is 0 whatever `cpu_dmem_we` is. Once the processor owns the port, `dmem_we` equals `cpu_dmem_we`.
- R7: The copy ends 2*IMG_LEN cycles after reset release. In the first cycle after that, `boot_done`, `imem_sel_cpu` and `cpu_pc_zero` are 1 and `cpu_run` is 0. From the next cycle on, `cpu_run` is 1 and `cpu_pc_zero` is 0.
- R8: After the copy, `imem_addr` equals `cpu_fetch_addr` and `imem_we` stays 0. `boot_done` stays 1 until reset.
- R9: A reset that arrives in the middle of the copy or after it returns the block to the R1 state. The copy then restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_addr | output | ADDR_W | Read address to the boot ROM |
| rom_rdata | input | DATA_W | ROM data, one cycle after the address |
| cpu_fetch_addr | input | ADDR_W | Processor instruction fetch address |
| cpu_dmem_we | input | 1 | Processor data-memory write request |
| imem_addr | output | ADDR_W | Instruction RAM address (muxed) |
| imem_wdata | output | DATA_W | Instruction RAM write data |
| imem_we | output | 1 | Instruction RAM write enable |
| imem_sel_cpu | output | 1 | 1 when the processor owns the RAM port |
| dmem_we | output | 1 | Gated data-memory write enable |
| cpu_run | output | 1 | Processor execute enable |
| cpu_pc_zero | output | 1 | Forces the processor program counter to 0 |
| boot_done | output | 1 | Copy finished, held until reset |

## Verification
The bench uses an image length that is not a power of two. This exposes a copy that stops one word early or late, which would leave the last RAM word stale or write past the image. It drives random fetch addresses and data writes during the copy, so any leak of the processor's address or write strobe through the mux shows up at once. It checks that there is a one-cycle program-counter clear before the run enable rises, because a design that raised both together could start from a wrong address. It also resets in the middle of the copy, which catches a loader that resumes from its old address instead of address zero.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;
    typedef enum logic [1:0] {
        LD_READ  = 2'd0,
        LD_WRITE = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_e;
endpackage

// File: rtl/boot_ld_seq.sv
module boot_ld_seq
    import boot_ld_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int IMG_LEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    output ld_state_e         state,
    output logic [ADDR_W-1:0] ld_addr,
    output logic              run
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_LEN - 1);

    typedef struct packed {
        ld_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              run;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            LD_READ: seq_d.st = LD_WRITE;
            LD_WRITE: begin
                if (seq_q.addr == LAST_ADDR) begin
                    seq_d.st = LD_DONE;
                end else begin
                    seq_d.st   = LD_READ;
                    seq_d.addr = seq_q.addr + 1'b1;
                end
            end
            LD_DONE: seq_d.run = 1'b1;
            default: seq_d.st = LD_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: LD_READ, addr: '0, run: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state   = seq_q.st;
    assign ld_addr = seq_q.addr;
    assign run     = seq_q.run;
endmodule

// File: rtl/boot_ld_portmux.sv
module boot_ld_portmux #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              owner_cpu,
    input  logic              write_phase,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [ADDR_W-1:0] cpu_fetch_addr,
    input  logic              cpu_dmem_we,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [ADDR_W-1:0] imem_addr,
    output logic [DATA_W-1:0] imem_wdata,
    output logic              imem_we,
    output logic              dmem_we
);
    always_comb begin
        rom_addr   = owner_cpu ? '0 : ld_addr;
        imem_addr  = owner_cpu ? cpu_fetch_addr : ld_addr;
        imem_we    = !owner_cpu && write_phase;
        imem_wdata = imem_we ? rom_rdata : '0;
        dmem_we    = owner_cpu && cpu_dmem_we;
    end
endmodule

// File: rtl/boot_loader.sv
module boot_loader
    import boot_ld_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int IMG_LEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [ADDR_W-1:0] cpu_fetch_addr,
    input  logic              cpu_dmem_we,
    output logic [ADDR_W-1:0] imem_addr,
    output logic [DATA_W-1:0] imem_wdata,
    output logic              imem_we,
    output logic              imem_sel_cpu,
    output logic              dmem_we,
    output logic              cpu_run,
    output logic              cpu_pc_zero,
    output logic              boot_done
);
    ld_state_e         state;
    logic [ADDR_W-1:0] ld_addr;
    logic              run;

    boot_ld_seq #(.ADDR_W(ADDR_W), .IMG_LEN(IMG_LEN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .ld_addr (ld_addr),
        .run     (run)
    );

    assign boot_done    = (state == LD_DONE);
    assign imem_sel_cpu = boot_done;
    assign cpu_run      = run;
    assign cpu_pc_zero  = boot_done && !run;

    boot_ld_portmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .owner_cpu      (boot_done),
        .write_phase    (state == LD_WRITE),
        .ld_addr        (ld_addr),
        .rom_rdata      (rom_rdata),
        .cpu_fetch_addr (cpu_fetch_addr),
        .cpu_dmem_we    (cpu_dmem_we),
        .rom_addr       (rom_addr),
        .imem_addr      (imem_addr),
        .imem_wdata     (imem_wdata),
        .imem_we        (imem_we),
        .dmem_we        (dmem_we)
    );
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [ADDR_W-1:0] imem_addr,
    input logic              imem_we,
    input logic              imem_sel_cpu,
    input logic              dmem_we,
    input logic              cpu_run,
    input logic              cpu_pc_zero,
    input logic              boot_done
);
    assert_we_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we |-> !imem_sel_cpu);
    assert_write_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we |-> (imem_addr == $past(rom_addr)));
    assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we |=> !imem_we);
    assert_hold_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> !cpu_run);
    assert_fetch_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !imem_sel_cpu |-> (imem_addr == rom_addr));
    assert_dmem_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !imem_sel_cpu |-> !dmem_we);
    assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_done) |-> (cpu_pc_zero && imem_sel_cpu && !cpu_run));
    assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_pc_zero |=> (cpu_run && !cpu_pc_zero));
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);
    assert_no_write_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> !imem_we);
endmodule

bind boot_loader boot_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rom_addr     (rom_addr),
    .imem_addr    (imem_addr),
    .imem_we      (imem_we),
    .imem_sel_cpu (imem_sel_cpu),
    .dmem_we      (dmem_we),
    .cpu_run      (cpu_run),
    .cpu_pc_zero  (cpu_pc_zero),
    .boot_done    (boot_done)
);

// File: tb/tb_boot_loader.sv
module tb_boot_loader;
    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int LEN = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_rdata = '0;
    logic [AW-1:0] cpu_fetch_addr = '0;
    logic          cpu_dmem_we = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [DW-1:0] imem_wdata;
    logic          imem_we, imem_sel_cpu, dmem_we, cpu_run, cpu_pc_zero, boot_done;

    int n_chk = 0;
    int n_fail = 0;
    int n_writes = 0;
    int img_seed = 0;
    logic [DW-1:0] iram [2**AW];

    always #4 clk = ~clk;

    boot_loader #(.ADDR_W(AW), .DATA_W(DW), .IMG_LEN(LEN)) dut (.*);

    function automatic logic [DW-1:0] img_byte(int k);
        return DW'((k * 29 + img_seed) ^ (k * k));
    endfunction

    always @(posedge clk) begin
        rom_rdata <= img_byte(int'(rom_addr));
        if (imem_we) begin
            iram[imem_addr] <= imem_wdata;
            n_writes <= n_writes + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_random();
        cpu_fetch_addr = AW'($urandom);
        cpu_dmem_we    = 1'($urandom);
    endtask

    task automatic check_reset_state(input string req);
        chk(req, int'(rom_addr), 0);
        chk(req, int'(imem_we), 0);
        chk(req, int'(boot_done), 0);
        chk(req, int'(cpu_run), 0);
        chk(req, int'(imem_sel_cpu), 0);
        chk(req, int'(cpu_pc_zero), 0);
        chk(req, int'(dmem_we), 0);
    endtask

    // Entered at the negedge where reset is released; walks the whole copy.
    task automatic run_load();
        for (int c = 0; c < 2 * LEN; c++) begin
            if (c > 0) @(negedge clk);
            drive_random();
            #1;
            chk("R4", int'(cpu_run), 0);
            chk("R6", int'(dmem_we), 0);
            chk("R5", int'(imem_addr), c / 2);
            if (c % 2 == 0) begin
                chk("R2", int'(rom_addr), c / 2);
                chk("R2", int'(imem_we), 0);
            end else begin
                chk("R2", int'(imem_we), 1);
                chk("R2", int'(imem_wdata), int'(img_byte(c / 2)));
            end
        end
        @(negedge clk);
        drive_random();
        #1;
        chk("R7", int'(boot_done), 1);
        chk("R7", int'(imem_sel_cpu), 1);
        chk("R7", int'(cpu_pc_zero), 1);
        chk("R7", int'(cpu_run), 0);
        @(negedge clk);
        #1;
        chk("R7", int'(cpu_run), 1);
        chk("R7", int'(cpu_pc_zero), 0);
    endtask

    task automatic check_image();
        chk("R3", n_writes, LEN);
        for (int k = 0; k < LEN; k++) chk("R3", int'(iram[k]), int'(img_byte(k)));
        chk("R3", int'(iram[LEN]), 8'hEE);
    endtask

    task automatic clear_iram();
        for (int k = 0; k < 2**AW; k++) iram[k] = 8'hEE;
        n_writes = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_B007));
        img_seed = int'($urandom % 256);
        clear_iram();
        cpu_dmem_we = 1'b1;
        cpu_fetch_addr = AW'(37);
        repeat (3) @(negedge clk);
        #1;
        check_reset_state("R1");

        // Full copy and handoff
        @(negedge clk);
        rst_n = 1'b1;
        run_load();
        check_image();

        // Processor owns the port
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            drive_random();
            if (i == 0) cpu_dmem_we = 1'b1;
            if (i == 1) cpu_dmem_we = 1'b0;
            #1;
            chk("R8", int'(imem_addr), int'(cpu_fetch_addr));
            chk("R8", int'(imem_we), 0);
            chk("R8", int'(boot_done), 1);
            chk("R6", int'(dmem_we), int'(cpu_dmem_we));
        end
        chk("R8", n_writes, LEN);

        // Reset in the middle of a copy
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("R9");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        cpu_dmem_we = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check_reset_state("R9");
        clear_iram();
        @(negedge clk);
        rst_n = 1'b1;
        run_load();
        check_image();

        // Reset after completion clears the done flag
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("R9");
        chk("R8", int'(boot_done), 0);
        finish_run();
    end
endmodule